// File: doc/BRIEF.md
# Token-Ring Polled Status Bus Driver

This block time-shares a narrow status bus among several devices. Each device holds a wide status word made of several fixed-width quadrants. While it owns the bus, the device puts one quadrant on the bus per read-clock edge. It walks through every quadrant in ascending order, and the number of quadrants in use makes no difference to this walk. A single-cycle token then passes ownership to the next device. The token-outputs and token-inputs of the devices are wired into a closed ring, so ownership returns to the first device after every other device has had its turn.

Exactly one device is strapped as the master. At the first read-clock edge after master reset is released, the master starts the ring by itself. Every other device waits idle until it receives a token. A per-device sync marker is HIGH only while that device's first quadrant is on the bus, so a listener can align to each turn. A mode pin is captured during reset. When it is LOW, the block stays quiet so that another bus scheme can be used. The bus output comes with an enable. The pad-level tri-state is built outside this block, and the data lines are driven to zero while the enable is LOW.

Top module: `poll_token_bus`

## Requirements
- R1: The mode pin is captured on every clock edge while reset is HIGH (HIGH selects polled operation). Changes on the pin after reset is released have no effect until the next reset.
- R2: In direct mode (pin LOW at reset), bus_oe_o, sync_o and tok_out_o stay LOW and bus_o stays 0. Token pulses have no effect.
- R3: In polled mode, a master device drives quadrant 0 with bus_oe_o HIGH at the first rising edge after reset falls.
- R4: While owning, the device drives quadrant q, which is flags_i[8q+7:8q], for one cycle each, in the order 0,1,2,3, advancing on every rising edge.
- R5: sync_o is HIGH exactly in the cycles in which quadrant 0 is on the bus, and LOW in the other three quadrant cycles.
- R6: tok_out_o is HIGH for exactly the cycle in which quadrant 3 is on the bus, and LOW at every other time.
- R7: If tok_in_i is HIGH at a rising edge while the device is idle or showing quadrant 3, the device drives quadrant 0 from that edge. A looped-back single device therefore repeats its four quadrants with no gap.
- R8: After quadrant 3, if no token is present, the device releases the bus: bus_oe_o goes LOW and bus_o goes to 0.
- R9: A token received while the device shows quadrants 0 to 2 is ignored, and the sequence continues with the next quadrant.
- R10: A non-master device in polled mode stays idle after reset until a token arrives.
- R11: While reset is HIGH, all outputs are LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high master reset |
| poll_mode_i | input | 1 | Mode select, captured during reset (1 = polled) |
| master_i | input | 1 | Strap: this device starts the ring |
| tok_in_i | input | 1 | Token from the previous device in the ring |
| flags_i | input | 32 | Status word, four 8-bit quadrants |
| bus_o | output | 8 | Quadrant data, 0 when not owning |
| bus_oe_o | output | 1 | Bus drive enable |
| sync_o | output | 1 | HIGH while this device's quadrant 0 is on the bus |
| tok_out_o | output | 1 | One-cycle token to the next device |

## Verification
Two events can fall on the same edge. One is the end of a device's own turn, after quadrant 3. The other is a token arriving on tok_in_i, and the order in which the block decides between them matters. The bench provokes this in two ways. It loops tok_out_o back to tok_in_i, and separately it pulses the token during the quadrant-3 cycle. The expected result is that quadrant 0 with sync follows quadrant 3 directly, with no idle cycle and no release of the enable. The bench also pulses the token in the middle of a turn, and there it expects no restart.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
  // Next-cycle ownership summary handed from the sequencer to the drivers
  typedef struct packed {
    logic own;    // device drives the bus next cycle
    logic first;  // next quadrant is quadrant 0
    logic last;   // next quadrant is the final quadrant
  } tpb_turn_t;
endpackage

// File: rtl/tpb_mode_latch.sv
module tpb_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic poll_mode_i,
  input  logic master_i,
  output logic poll_en,
  output logic start_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      poll_en   <= poll_mode_i;
      start_req <= poll_mode_i & master_i;
    end else begin
      start_req <= 1'b0;
    end
  end

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(poll_en));

  // R3
  start_once_chk: assert property (@(posedge clk) disable iff (rst)
    start_req |=> !start_req);
endmodule

// File: rtl/tpb_owner_seq.sv
module tpb_owner_seq
  import tpb_pkg::*;
#(
  parameter int QUADS  = 4,
  parameter int QIDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_en,
  input  logic              start_req,
  input  logic              tok_in,
  output tpb_turn_t         nxt_turn,
  output logic [QIDX_W-1:0] nxt_quad
);
  localparam logic [QIDX_W-1:0] LAST = QIDX_W'(QUADS - 1);

  logic              own_q;
  logic [QIDX_W-1:0] quad_q;
  logic              nxt_own;

  // Mid-turn: keep stepping, tokens ignored. End of turn or idle: token/start opens a turn.
  always_comb begin
    nxt_own  = 1'b0;
    nxt_quad = '0;
    if (poll_en) begin
      if (own_q && (quad_q != LAST)) begin
        nxt_own  = 1'b1;
        nxt_quad = quad_q + 1'b1;
      end else if (tok_in || start_req) begin
        nxt_own  = 1'b1;
        nxt_quad = '0;
      end
    end
  end

  assign nxt_turn.own   = nxt_own;
  assign nxt_turn.first = nxt_own && (nxt_quad == '0);
  assign nxt_turn.last  = nxt_own && (nxt_quad == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q  <= 1'b0;
      quad_q <= '0;
    end else begin
      own_q  <= nxt_own;
      quad_q <= nxt_quad;
    end
  end

  // R4 R9
  quad_step_chk: assert property (@(posedge clk) disable iff (rst)
    (own_q && quad_q != LAST) |=> (own_q && quad_q == $past(quad_q) + 1'b1));

  // R10
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (!own_q && !tok_in && !start_req) |=> !own_q);
endmodule

// File: rtl/tpb_quad_drive.sv
module tpb_quad_drive
  import tpb_pkg::*;
#(
  parameter int QUADS  = 4,
  parameter int QUAD_W = 8,
  parameter int QIDX_W = 2,
  localparam int FLAG_W = QUADS * QUAD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  tpb_turn_t         nxt_turn,
  input  logic [QIDX_W-1:0] nxt_quad,
  input  logic [FLAG_W-1:0] flags,
  output logic [QUAD_W-1:0] bus_o,
  output logic              oe_o,
  output logic              sync_o,
  output logic              tok_o
);
  logic [QUAD_W-1:0] slice;

  always_comb begin
    slice = flags[nxt_quad*QUAD_W +: QUAD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_o  <= '0;
      oe_o   <= 1'b0;
      sync_o <= 1'b0;
      tok_o  <= 1'b0;
    end else begin
      bus_o  <= nxt_turn.own ? slice : '0;
      oe_o   <= nxt_turn.own;
      sync_o <= nxt_turn.first;
      tok_o  <= nxt_turn.last;
    end
  end

  // R5
  sync_oe_chk: assert property (@(posedge clk) disable iff (rst)
    sync_o |-> oe_o);

  // R6
  tok_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tok_o |=> !tok_o);

  // R5
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> !sync_o);

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_o |-> (bus_o == '0));
endmodule

// File: rtl/poll_token_bus.sv
module poll_token_bus
  import tpb_pkg::*;
#(
  parameter int QUADS  = 4,
  parameter int QUAD_W = 8,
  localparam int FLAG_W = QUADS * QUAD_W,
  localparam int QIDX_W = (QUADS > 1) ? $clog2(QUADS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              poll_mode_i,
  input  logic              master_i,
  input  logic              tok_in_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [QUAD_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              sync_o,
  output logic              tok_out_o
);
  logic              poll_en;
  logic              start_req;
  tpb_turn_t         nxt_turn;
  logic [QIDX_W-1:0] nxt_quad;

  tpb_mode_latch u_mode (
    .clk        (clk),
    .rst        (rst),
    .poll_mode_i(poll_mode_i),
    .master_i   (master_i),
    .poll_en    (poll_en),
    .start_req  (start_req)
  );

  tpb_owner_seq #(.QUADS(QUADS), .QIDX_W(QIDX_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .poll_en  (poll_en),
    .start_req(start_req),
    .tok_in   (tok_in_i),
    .nxt_turn (nxt_turn),
    .nxt_quad (nxt_quad)
  );

  tpb_quad_drive #(.QUADS(QUADS), .QUAD_W(QUAD_W), .QIDX_W(QIDX_W)) u_drv (
    .clk     (clk),
    .rst     (rst),
    .nxt_turn(nxt_turn),
    .nxt_quad(nxt_quad),
    .flags   (flags_i),
    .bus_o   (bus_o),
    .oe_o    (bus_oe_o),
    .sync_o  (sync_o),
    .tok_o   (tok_out_o)
  );

  // R2
  direct_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !poll_en |-> (!bus_oe_o && !sync_o && !tok_out_o));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_out_o && !tok_in_i) |=> !bus_oe_o);

  // R7
  handoff_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_out_o && tok_in_i) |=> (bus_oe_o && sync_o));
endmodule

// File: tb/poll_token_bus_test.sv
`timescale 1ns/1ps
module poll_token_bus_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        poll_mode = 1'b1;
  logic        master = 1'b1;
  logic        tb_tok = 1'b0;
  logic        loop_en = 1'b0;
  logic [31:0] flags = 32'h0;
  logic        tok_in;
  logic [7:0]  bus;
  logic        oe, sync, tok_out;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  assign tok_in = loop_en ? tok_out : tb_tok;

  poll_token_bus uut (
    .clk(clk), .rst(rst), .poll_mode_i(poll_mode), .master_i(master),
    .tok_in_i(tok_in), .flags_i(flags), .bus_o(bus), .bus_oe_o(oe),
    .sync_o(sync), .tok_out_o(tok_out)
  );

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expect_quad(input string req, input int q);
    check({req, " oe"},   {31'b0, oe},      32'd1);
    check({req, " bus"},  {24'b0, bus},     {24'b0, flags[q*8 +: 8]});
    check({req, " sync"}, {31'b0, sync},    {31'b0, q == 0});
    check({req, " tok"},  {31'b0, tok_out}, {31'b0, q == 3});
  endtask

  task automatic expect_idle(input string req);
    check({req, " oe"},   {31'b0, oe},      32'd0);
    check({req, " bus"},  {24'b0, bus},     32'd0);
    check({req, " sync"}, {31'b0, sync},    32'd0);
    check({req, " tok"},  {31'b0, tok_out}, 32'd0);
  endtask

  task automatic do_reset(input logic mode, input logic mas);
    tick;
    rst = 1'b1; poll_mode = mode; master = mas; tb_tok = 1'b0;
    repeat (3) tick;
    expect_idle("R11 reset");
    rst = 1'b0;
  endtask

  task automatic t_master_turn;
    flags = 32'hA4B3_C2D1;
    do_reset(1'b1, 1'b1);
    poll_mode = 1'b0;  // R1: ignored after reset
    for (int q = 0; q < 4; q++) begin
      tick;
      expect_quad(q == 0 ? "R3 start" : "R4 R1 step", q);
    end
    tick; expect_idle("R8 release");
    tick; expect_idle("R8 stay idle");
  endtask

  task automatic t_token_resume;
    flags = 32'h1122_3344;
    tb_tok = 1'b1;
    tick; expect_quad("R7 idle token", 0);
    tb_tok = 1'b0;
    tick; expect_quad("R4 q1", 1);
    tb_tok = 1'b1;
    tick; expect_quad("R9 mid-turn token ignored", 2);
    tb_tok = 1'b0;
    tick; expect_quad("R6 q3", 3);
    tb_tok = 1'b1;
    tick; expect_quad("R7 token at q3", 0);
    tb_tok = 1'b0;
    for (int q = 1; q < 4; q++) begin
      tick; expect_quad("R4 after handoff", q);
    end
    tick; expect_idle("R8 release2");
  endtask

  task automatic t_loopback;
    flags = 32'h5A69_7887;
    loop_en = 1'b1;
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 12; i++) begin
      tick; expect_quad("R7 R5 loopback", i % 4);
    end
    tick; loop_en = 1'b0;
  endtask

  task automatic t_nonmaster;
    flags = 32'hF00D_BEEF;
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      tick; expect_idle("R10 waits");
    end
    tb_tok = 1'b1;
    tick; expect_quad("R10 token start", 0);
    tb_tok = 1'b0;
    flags = 32'h0102_0304;  // live flags sampled per edge
    for (int q = 1; q < 4; q++) begin
      tick; expect_quad("R4 nonmaster", q);
    end
    tick; expect_idle("R8 nonmaster release");
  endtask

  task automatic t_direct;
    flags = 32'hFFFF_FFFF;
    do_reset(1'b0, 1'b1);
    poll_mode = 1'b1;  // R1: too late
    for (int i = 0; i < 4; i++) begin
      tick; expect_idle("R2 R1 direct");
    end
    tb_tok = 1'b1;
    tick; expect_idle("R2 token ignored");
    tb_tok = 1'b0;
    tick; expect_idle("R2 after token");
  endtask

  initial begin
    t_master_turn;
    t_token_resume;
    t_loopback;
    t_nonmaster;
    t_direct;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule